// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Marker

This block sits between instruction fetch and a small bank of full decoders. It takes one 16-byte window of a byte-granular, variable-length instruction stream. It works out which byte offsets in that window begin real instructions. Every byte offset has its own length-only decoder, which assumes that an instruction begins at that byte. A start chain then begins at the window's known entry offset. It keeps only the offsets reached by stepping forward one decoded length at a time. The speculative results at every other byte are dropped.

At most four starts leave the block per cycle, packed from lane 0 in ascending offset order. Each start carries its offset, its decoded length and a flag that marks an instruction running past the end of the window. A dense window can hold more than four instructions. In that case the block keeps the window, drops its fetch-ready signal and drains the leftover starts over the following cycles. An instruction that crosses into the next window leaves a byte count behind, and that count becomes the entry offset of the next window. A flush input discards all of this and restarts at an offset given with the flush.

The encoding is deliberately minimal. The low four bits of an instruction's first byte hold its length minus one.

Top module: `vlb_boundary_marker`

## Requirements
- R1: The length of an instruction starting at a byte is that byte's bits [3:0] plus one (1 to 16), and it is reported on the lane's length field.
- R2: The first start reported for a window is its entry offset. Each later start is the previous start plus its length. No offset that falls inside a reported instruction is ever reported.
- R3: At most four starts are presented per cycle. Valid lanes are packed from lane 0 upward, and offsets rise with lane number.
- R4: When a window holds more than four starts, fetch_ready is low until the last of them has been presented. The leftover starts follow in later cycles in ascending order. A window offered while fetch_ready is low is ignored.
- R5: A lane's partial flag is set exactly when offset plus length exceeds 16. Only the last start of a window can carry it.
- R6: The next window's entry offset is offset plus length minus 16 of the straddling instruction. It is 0 when the last instruction ends exactly at byte 15.
- R7: Starts of a window accepted at a clock edge appear on the outputs registered at that same edge. out_valid is zero in cycles with no accepted or pending window.
- R8: A flush clears pending starts and the overhang. The cycle after it shows no valid lanes and fetch_ready high. The next window begins at flush_off. A window offered together with a flush is dropped.
- R9: After reset, out_valid is zero, fetch_ready is high and the first window begins at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | A fetch window is offered |
| win_data | input | 128 | Window bytes, byte i at bits [8i+7:8i] |
| flush | input | 1 | Discard state and restart |
| flush_off | input | 4 | Entry offset used after a flush |
| fetch_ready | output | 1 | Block can take a new window |
| out_valid | output | 4 | Per-lane start valid |
| out_off | output | 16 | Per-lane start offset, lane k at [4k+3:4k] |
| out_len | output | 20 | Per-lane decoded length, lane k at [5k+4:5k] |
| out_part | output | 4 | Per-lane flag: instruction runs past byte 15 |

## Verification
On every cycle, the assertions check the shape of the output bundle. Valid lanes are packed from lane 0, offsets rise across the lanes, and a partial flag appears only on the last valid lane. A stalled cycle shows four full lanes and is followed by more output. A flush always leaves an empty, ready cycle behind it. Whether the reported offsets are the true instruction boundaries, whether the lengths and overhang values are correct, and whether windows offered during a stall are really ignored can only be shown by the bench. It does this by comparing each drained window against a serial walk of random and directed byte streams.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  // Default geometry shared by the block and its checker.
  localparam int VLB_WIN_BYTES = 16;
  localparam int VLB_LANES     = 4;
  localparam int VLB_LEN_BITS  = 4;
endpackage

// File: rtl/vlb_len_dec.sv
// Length-only decode of one byte, assuming an instruction starts there.
module vlb_len_dec #(
  parameter int LEN_BITS = vlb_pkg::VLB_LEN_BITS,
  localparam int LEN_W = LEN_BITS + 1
) (
  input  logic [7:0]       byte_in,
  output logic [LEN_W-1:0] len_out
);
  assign len_out = {1'b0, byte_in[LEN_BITS-1:0]} + LEN_W'(1);
endmodule

// File: rtl/vlb_start_chain.sv
// Walks from the entry offset through the speculative lengths, marking real starts.
module vlb_start_chain #(
  parameter int WIN_BYTES = vlb_pkg::VLB_WIN_BYTES,
  parameter int LEN_BITS  = vlb_pkg::VLB_LEN_BITS,
  localparam int OFF_W = $clog2(WIN_BYTES),
  localparam int LEN_W = LEN_BITS + 1,
  localparam int SUM_W = $clog2(WIN_BYTES + (1 << LEN_BITS))
) (
  input  logic [WIN_BYTES*LEN_W-1:0] lens,
  input  logic [OFF_W-1:0]           entry,
  output logic [WIN_BYTES-1:0]       mark,
  output logic [OFF_W-1:0]           carry_off
);
  localparam logic [SUM_W-1:0] WIN_N = SUM_W'(WIN_BYTES);

  always_comb begin
    logic [SUM_W-1:0] nxt;
    mark      = '0;
    carry_off = '0;
    nxt       = '0;
    mark[entry] = 1'b1;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (mark[i]) begin
        nxt = SUM_W'(i) + SUM_W'(lens[i*LEN_W +: LEN_W]);
        if (nxt < WIN_N) mark[nxt[OFF_W-1:0]] = 1'b1;
        else             carry_off = OFF_W'(nxt - WIN_N);
      end
    end
  end
endmodule

// File: rtl/vlb_pick.sv
// Takes the lowest LANES set bits of a start mask, in ascending order.
module vlb_pick #(
  parameter int WIN_BYTES = vlb_pkg::VLB_WIN_BYTES,
  parameter int LANES     = vlb_pkg::VLB_LANES,
  localparam int OFF_W = $clog2(WIN_BYTES)
) (
  input  logic [WIN_BYTES-1:0]   mask,
  output logic [LANES-1:0]       lane_valid,
  output logic [LANES*OFF_W-1:0] lane_idx,
  output logic [WIN_BYTES-1:0]   rest
);
  always_comb begin
    logic [WIN_BYTES-1:0] m;
    logic                 found;
    logic [OFF_W-1:0]     pos;
    m          = mask;
    lane_valid = '0;
    lane_idx   = '0;
    found      = 1'b0;
    pos        = '0;
    for (int k = 0; k < LANES; k++) begin
      found = 1'b0;
      pos   = '0;
      for (int j = 0; j < WIN_BYTES; j++) begin
        if (!found && m[j]) begin
          found = 1'b1;
          pos   = OFF_W'(j);
        end
      end
      lane_valid[k] = found;
      lane_idx[k*OFF_W +: OFF_W] = pos;
      if (found) m[pos] = 1'b0;
    end
    rest = m;
  end
endmodule

// File: rtl/vlb_boundary_marker.sv
module vlb_boundary_marker #(
  parameter int WIN_BYTES = vlb_pkg::VLB_WIN_BYTES,
  parameter int LANES     = vlb_pkg::VLB_LANES,
  parameter int LEN_BITS  = vlb_pkg::VLB_LEN_BITS
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  win_valid,
  input  logic [WIN_BYTES*8-1:0]                win_data,
  input  logic                                  flush,
  input  logic [$clog2(WIN_BYTES)-1:0]          flush_off,
  output logic                                  fetch_ready,
  output logic [LANES-1:0]                      out_valid,
  output logic [LANES*$clog2(WIN_BYTES)-1:0]    out_off,
  output logic [LANES*(LEN_BITS+1)-1:0]         out_len,
  output logic [LANES-1:0]                      out_part
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int LEN_W = LEN_BITS + 1;
  localparam int SUM_W = $clog2(WIN_BYTES + (1 << LEN_BITS));

  logic [WIN_BYTES*8-1:0]     hold_q;
  logic [WIN_BYTES-1:0]       pend_q;
  logic                       busy_q;
  logic [OFF_W-1:0]           entry_q;

  logic                       accept;
  logic [WIN_BYTES*8-1:0]     src_data;
  logic [WIN_BYTES*LEN_W-1:0] len_vec;
  logic [WIN_BYTES-1:0]       chain_mark;
  logic [OFF_W-1:0]           carry_off;
  logic [WIN_BYTES-1:0]       src_mask;
  logic [LANES-1:0]           lane_valid;
  logic [LANES*OFF_W-1:0]     lane_idx;
  logic [WIN_BYTES-1:0]       rest;
  logic [LEN_W-1:0]           lane_len [LANES];
  logic [LANES-1:0]           lane_part;

  assign accept      = win_valid & ~busy_q & ~flush;
  assign src_data    = busy_q ? hold_q : win_data;
  assign fetch_ready = ~busy_q;

  // One speculative length decoder per byte offset.
  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_lendec
    vlb_len_dec #(.LEN_BITS(LEN_BITS)) u_dec (
      .byte_in (src_data[b*8 +: 8]),
      .len_out (len_vec[b*LEN_W +: LEN_W])
    );
  end

  vlb_start_chain #(.WIN_BYTES(WIN_BYTES), .LEN_BITS(LEN_BITS)) u_chain (
    .lens      (len_vec),
    .entry     (entry_q),
    .mark      (chain_mark),
    .carry_off (carry_off)
  );

  assign src_mask = busy_q ? pend_q : chain_mark;

  vlb_pick #(.WIN_BYTES(WIN_BYTES), .LANES(LANES)) u_pick (
    .mask       (src_mask),
    .lane_valid (lane_valid),
    .lane_idx   (lane_idx),
    .rest       (rest)
  );

  always_comb begin
    logic [OFF_W-1:0] li;
    li = '0;
    for (int k = 0; k < LANES; k++) begin
      li          = lane_idx[k*OFF_W +: OFF_W];
      lane_len[k] = len_vec[int'(li)*LEN_W +: LEN_W];
      lane_part[k] = lane_valid[k] &&
                     ((SUM_W'(li) + SUM_W'(lane_len[k])) > SUM_W'(WIN_BYTES));
    end
  end

  // Window storage: plain data register, no reset needed.
  always_ff @(posedge clk) begin
    if (accept) hold_q <= win_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      pend_q    <= '0;
      entry_q   <= '0;
      out_valid <= '0;
      out_part  <= '0;
      out_off   <= '0;
      out_len   <= '0;
    end else if (flush) begin
      busy_q    <= 1'b0;
      pend_q    <= '0;
      entry_q   <= flush_off;
      out_valid <= '0;
      out_part  <= '0;
    end else if (accept || busy_q) begin
      out_valid <= lane_valid;
      out_part  <= lane_part;
      for (int k = 0; k < LANES; k++) begin
        out_off[k*OFF_W +: OFF_W] <= lane_idx[k*OFF_W +: OFF_W];
        out_len[k*LEN_W +: LEN_W] <= lane_len[k];
      end
      pend_q <= rest;
      busy_q <= |rest;
      if (accept) entry_q <= carry_off;
    end else begin
      out_valid <= '0;
      out_part  <= '0;
    end
  end
endmodule

// File: rtl/vlb_checker.sv
module vlb_checker #(
  parameter int WIN_BYTES = vlb_pkg::VLB_WIN_BYTES,
  parameter int LANES     = vlb_pkg::VLB_LANES,
  localparam int OFF_W = $clog2(WIN_BYTES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   flush,
  input logic                   fetch_ready,
  input logic [LANES-1:0]       out_valid,
  input logic [LANES*OFF_W-1:0] out_off,
  input logic [LANES-1:0]       out_part
);
  p_lanes_packed_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid & (out_valid + LANES'(1))) == '0);

  for (genvar k = 0; k < LANES - 1; k++) begin : g_order
    p_ascending_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid[k+1] |-> (out_off[(k+1)*OFF_W +: OFF_W] > out_off[k*OFF_W +: OFF_W]));
    p_partial_last_r5: assert property (@(posedge clk) disable iff (rst)
      out_part[k] |-> !out_valid[k+1]);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_part
    p_partial_valid_r5: assert property (@(posedge clk) disable iff (rst)
      out_part[k] |-> out_valid[k]);
  end

  p_stall_full_r4: assert property (@(posedge clk) disable iff (rst)
    !fetch_ready |-> (&out_valid));

  p_stall_drains_r4: assert property (@(posedge clk) disable iff (rst)
    (!fetch_ready && !flush) |=> out_valid[0]);

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_valid == '0 && fetch_ready));
endmodule

bind vlb_boundary_marker vlb_checker #(.WIN_BYTES(WIN_BYTES), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flush       (flush),
  .fetch_ready (fetch_ready),
  .out_valid   (out_valid),
  .out_off     (out_off),
  .out_part    (out_part)
);

// File: tb/sim_vlb_boundary_marker.sv
module sim_vlb_boundary_marker;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         win_valid = 1'b0;
  logic [127:0] win_data = '0;
  logic         flush = 1'b0;
  logic [3:0]   flush_off = '0;
  logic         fetch_ready;
  logic [3:0]   out_valid;
  logic [15:0]  out_off;
  logic [19:0]  out_len;
  logic [3:0]   out_part;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] wb [16];
  int e_off [16];
  int e_len [16];
  int e_part [16];
  int e_n;
  int next_entry;
  int m_entry;

  always #10 clk = ~clk;

  vlb_boundary_marker u0 (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_data(win_data),
    .flush(flush), .flush_off(flush_off), .fetch_ready(fetch_ready),
    .out_valid(out_valid), .out_off(out_off), .out_len(out_len), .out_part(out_part)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Serial walk of the window from an entry offset.
  task automatic model_walk(input int entry);
    int s;
    int l;
    s = entry;
    e_n = 0;
    while (s < 16) begin
      l = int'(wb[s][3:0]) + 1;
      e_off[e_n]  = s;
      e_len[e_n]  = l;
      e_part[e_n] = (s + l > 16) ? 1 : 0;
      e_n++;
      s += l;
    end
    next_entry = (s > 16) ? s - 16 : 0;
  endtask

  function automatic logic [127:0] pack_win();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = wb[i];
    return v;
  endfunction

  task automatic run_window(input bit junk);
    int got;
    int cnt;
    int guard;
    model_walk(m_entry);
    @(negedge clk);
    win_valid = 1'b1;
    win_data  = pack_win();
    @(negedge clk);
    win_valid = junk;
    if (junk) win_data = {$urandom, $urandom, $urandom, $urandom};
    got = 0;
    guard = 0;
    while (1) begin
      cnt = (e_n - got > 4) ? 4 : e_n - got;
      // R3: packed lanes, R7: present in the cycle after acceptance
      chk(out_valid == 4'((1 << cnt) - 1), "R3 lane count", int'(out_valid), (1 << cnt) - 1);
      for (int k = 0; k < 4; k++) begin
        if (k < cnt) begin
          // R2 offsets, R1 lengths, R5 partial flag
          chk(int'(out_off[k*4 +: 4]) == e_off[got+k], "R2 offset",
              int'(out_off[k*4 +: 4]), e_off[got+k]);
          chk(int'(out_len[k*5 +: 5]) == e_len[got+k], "R1 length",
              int'(out_len[k*5 +: 5]), e_len[got+k]);
          chk(int'(out_part[k]) == e_part[got+k], "R5 partial",
              int'(out_part[k]), e_part[got+k]);
        end
      end
      got += cnt;
      // R4: ready only once drained
      chk(int'(fetch_ready) == ((got == e_n) ? 1 : 0), "R4 fetch_ready",
          int'(fetch_ready), (got == e_n) ? 1 : 0);
      guard++;
      if (fetch_ready || guard > 6 || got >= e_n) break;
      @(negedge clk);
      if (junk) win_data = {$urandom, $urandom, $urandom, $urandom};
    end
    win_valid = 1'b0;
    m_entry = next_entry;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_entry = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 4'd0, "R9 out_valid", int'(out_valid), 0);
    chk(fetch_ready == 1'b1, "R9 fetch_ready", int'(fetch_ready), 1);

    // R4: sixteen one-byte instructions drain over four cycles; R9 entry 0
    for (int i = 0; i < 16; i++) wb[i] = 8'h00;
    run_window(1'b0);
    // R4 again with junk offered while stalled
    for (int i = 0; i < 16; i++) wb[i] = 8'hA0;
    run_window(1'b1);

    // R6: length 16 at offset 0 ends exactly, next entry 0
    for (int i = 0; i < 16; i++) wb[i] = 8'h3F;
    run_window(1'b0);
    // R6: straddle by one byte
    wb[0] = 8'h00; wb[1] = 8'h0F;
    run_window(1'b0);
    chk(m_entry == 1, "R6 model overhang", m_entry, 1);
    for (int i = 0; i < 16; i++) wb[i] = 8'h01;
    run_window(1'b0);

    // R8: flush while stalled
    for (int i = 0; i < 16; i++) wb[i] = 8'h00;
    m_entry = 0;
    @(negedge clk);
    flush = 1'b1; flush_off = 4'd0;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
    win_valid = 1'b1; win_data = pack_win();
    @(negedge clk);
    win_valid = 1'b0;
    chk(fetch_ready == 1'b0, "R4 stall before flush", int'(fetch_ready), 0);
    flush = 1'b1; flush_off = 4'd9;
    @(negedge clk);
    flush = 1'b0;
    chk(out_valid == 4'd0, "R8 flush clears lanes", int'(out_valid), 0);
    chk(fetch_ready == 1'b1, "R8 flush ready", int'(fetch_ready), 1);
    @(negedge clk);
    chk(out_valid == 4'd0, "R7 idle lanes", int'(out_valid), 0);
    m_entry = 9;
    for (int i = 0; i < 16; i++) wb[i] = 8'(i);
    run_window(1'b0);

    // R8: window offered with flush is dropped
    @(negedge clk);
    win_valid = 1'b1; win_data = {$urandom, $urandom, $urandom, $urandom};
    flush = 1'b1; flush_off = 4'd15;
    @(negedge clk);
    win_valid = 1'b0; flush = 1'b0;
    chk(out_valid == 4'd0, "R8 window with flush dropped", int'(out_valid), 0);
    m_entry = 15;
    // R5/R6: entry 15, length 16 -> partial, overhang 15
    for (int i = 0; i < 16; i++) wb[i] = 8'h0F;
    run_window(1'b0);
    chk(m_entry == 15, "R6 model overhang 15", m_entry, 15);
    run_window(1'b0);

    // Random streams
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < 16; i++) begin
        wb[i] = 8'($urandom);
        if ($urandom_range(0, 1) == 0) wb[i][3:0] = 4'($urandom_range(0, 2));
      end
      run_window($urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule